// File: doc/BRIEF.md
# DMA Request Timeout Timer

This block watches one DMA channel for inactivity. A free-running prescaler divides the system clock down to a slow tick. A tick counter counts those ticks and raises a one-cycle timeout pulse when the selected number of ticks has passed with no restart. A restart is a beat-done pulse from the channel's data path, or the timer being switched on.

The prescaler is never cleared. Because of that, the first tick after a restart can arrive anywhere within one tick period, so the achieved timeout lies within a one-tick window below the nominal value. A request-wait mode can hold off counting after a restart until the request line makes an active-to-inactive transition. This suits peripherals that keep their request asserted while data is still being moved.

All pins are plain control and status signals; no data passes through, so there is no valid/ready handshake. The three divider ratios are parameters and must be powers of two, each no larger than the next.

Top module: `dma_req_timeout`

## Requirements
- R1: `psel_i` selects the tick rate: 0 = timer off, 1 = one tick every DIV_LO clocks, 2 = every DIV_MID clocks, 3 = every DIV_HI clocks (defaults 256, 65536, 2^24).
- R2: `tsel_i` = s selects a period of N = 2^(s+2) ticks, i.e. 4, 8, 16, 32, 64, 128, 256 or 512.
- R3: With counting started at clock edge e0 and divider D, `timeout_o` is first seen high after edge e0+E, where (N-1)*D+1 <= E <= N*D.
- R4: `timeout_o` is high for exactly one cycle. After it, the timer gives no further pulse until the next restart.
- R5: A `beat_done_i` pulse restarts the timer from zero ticks. It takes priority over a tick on the same edge, and pulses spaced closer than the period keep `timeout_o` low indefinitely.
- R6: While `psel_i` = 0 no timeout is produced. The edge on which `psel_i` becomes non-zero acts as a restart.
- R7: With `req_wait_i` = 1 at a restart, no ticks are counted until `req_i` falls from 1 to 0. Counting then begins from zero at that edge, and no timeout occurs while `req_i` stays high.
- R8: With `req_wait_i` = 0 at a restart, counting begins at once, whatever the level of `req_i`.
- R9: The prescaler phase is not affected by restarts, so the position of E inside the R3 window depends on when the restart falls relative to that phase.
- R10: During reset `timeout_o` is 0. The first enabled edge after reset acts as a restart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Channel request line, active high |
| beat_done_i | input | 1 | One-cycle pulse when a transfer beat completes; restarts the timer |
| req_wait_i | input | 1 | 1 = hold off counting until the request falls |
| psel_i | input | 2 | Prescale select (0 off, 1/2/3 = low/mid/high divider) |
| tsel_i | input | 3 | Timeout select, period 2^(tsel_i+2) ticks |
| timeout_o | output | 1 | One-cycle timeout pulse |

## Verification
The bench builds the block with dividers of 4, 8 and 16 clocks instead of the large defaults. With those values every prescale setting and every timeout setting, up to 512 ticks, completes within a few thousand cycles. The small divider also lets the bench place restarts at each phase of the prescaler, so both ends of the one-tick window are reached. The longest run at the 512-tick setting stays short enough to repeat alongside the disable, request-wait and restart-priority cases.

// File: rtl/rto_pkg.sv
package rto_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_HOLD  = 2'd3
  } rto_state_e;
endpackage

// File: rtl/rto_prescaler.sv
// Free-running phase counter with three power-of-two taps.
module rto_prescaler #(
  parameter int DIV_LO  = 256,
  parameter int DIV_MID = 65536,
  parameter int DIV_HI  = 16777216
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] psel_i,
  output logic       tick_o
);
  localparam int LG_LO  = $clog2(DIV_LO);
  localparam int LG_MID = $clog2(DIV_MID);
  localparam int LG_HI  = $clog2(DIV_HI);
  localparam int PH_W   = LG_HI;
  localparam int NTAP   = 3;
  localparam int LG [NTAP] = '{LG_LO, LG_MID, LG_HI};

  logic [PH_W-1:0] ph_q;
  logic [NTAP-1:0] tap;

  // phase never restarts except on reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= '0;
    else        ph_q <= ph_q + 1'b1;
  end

  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    assign tap[g] = &ph_q[LG[g]-1:0];
  end

  always_comb begin
    case (psel_i)
      2'd1:    tick_o = tap[0];
      2'd2:    tick_o = tap[1];
      2'd3:    tick_o = tap[2];
      default: tick_o = 1'b0;
    endcase
  end

  if (DIV_LO > 1) begin : g_chk
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tap[0] |=> !tap[0]); // R1
  end
endmodule

// File: rtl/rto_fall_det.sv
// Registers the request line and flags its active-to-inactive edge.
module rto_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  output logic fall_o
);
  logic req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= req_i;
  end

  assign fall_o = req_q & ~req_i;

  AST_FALL_FROM_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |-> $past(req_i)); // R7
endmodule

// File: rtl/rto_tick_counter.sv
// Start control, tick counter and timeout pulse.
module rto_tick_counter
  import rto_pkg::*;
#(
  parameter int TSEL_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              tick_i,
  input  logic              fall_i,
  input  logic              restart_i,
  input  logic              wait_i,
  input  logic [TSEL_W-1:0] tsel_i,
  output logic              timeout_o
);
  localparam int CNT_W = (1 << TSEL_W) + 2;

  rto_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;
  logic [CNT_W-1:0] period;
  logic             to_q;

  assign period  = {{(CNT_W-1){1'b0}}, 1'b1} << (int'(tsel_i) + 2);
  assign cnt_nxt = cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      to_q <= 1'b0;
      if (!en_i) begin
        st_q  <= ST_IDLE;
        cnt_q <= '0;
      end else if (st_q == ST_IDLE || restart_i) begin
        st_q  <= wait_i ? ST_ARMED : ST_RUN;
        cnt_q <= '0;
      end else begin
        case (st_q)
          ST_ARMED: begin
            if (fall_i) begin
              st_q  <= ST_RUN;
              cnt_q <= '0;
            end
          end
          ST_RUN: begin
            if (tick_i) begin
              cnt_q <= cnt_nxt;
              if (cnt_nxt >= period) begin
                st_q <= ST_HOLD;
                to_q <= 1'b1;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign timeout_o = to_q;

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_o |=> !timeout_o); // R4
  AST_HOLD_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HOLD && en_i && !restart_i) |=> (st_q == ST_HOLD && $stable(cnt_q))); // R4
  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!timeout_o && cnt_q == '0)); // R6
  AST_RESTART_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && restart_i) |=> (cnt_q == '0 && !timeout_o)); // R5
  AST_FIRES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout_o) |-> $past(tick_i)); // R3
  AST_ARMED_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_ARMED && en_i && !fall_i && !restart_i) |=> (st_q == ST_ARMED && cnt_q == '0)); // R7
endmodule

// File: rtl/dma_req_timeout.sv
module dma_req_timeout #(
  parameter int DIV_LO  = 256,
  parameter int DIV_MID = 65536,
  parameter int DIV_HI  = 16777216,
  parameter int TSEL_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              beat_done_i,
  input  logic              req_wait_i,
  input  logic [1:0]        psel_i,
  input  logic [TSEL_W-1:0] tsel_i,
  output logic              timeout_o
);
  logic tick;
  logic fall;
  logic en;

  assign en = (psel_i != 2'd0);

  rto_prescaler #(
    .DIV_LO (DIV_LO),
    .DIV_MID(DIV_MID),
    .DIV_HI (DIV_HI)
  ) u_pre (
    .clk   (clk),
    .rst_n (rst_n),
    .psel_i(psel_i),
    .tick_o(tick)
  );

  rto_fall_det u_fall (
    .clk   (clk),
    .rst_n (rst_n),
    .req_i (req_i),
    .fall_o(fall)
  );

  rto_tick_counter #(
    .TSEL_W(TSEL_W)
  ) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en),
    .tick_i   (tick),
    .fall_i   (fall),
    .restart_i(beat_done_i),
    .wait_i   (req_wait_i),
    .tsel_i   (tsel_i),
    .timeout_o(timeout_o)
  );
endmodule

// File: tb/sim_dma_req_timeout.sv
`timescale 1ns/1ps
module sim_dma_req_timeout;
  localparam int DA = 4;
  localparam int DB = 8;
  localparam int DC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req = 1'b0;
  logic       bd = 1'b0;
  logic       rw = 1'b0;
  logic [1:0] psel = 2'd1;
  logic [2:0] tsel = 3'd0;
  logic       timeout_o;

  int total = 0;
  int bad = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  dma_req_timeout #(.DIV_LO(DA), .DIV_MID(DB), .DIV_HI(DC), .TSEL_W(3)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req), .beat_done_i(bd),
    .req_wait_i(rw), .psel_i(psel), .tsel_i(tsel), .timeout_o(timeout_o)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // behavioural reference: 0 idle, 1 waiting for fall, 2 counting, 3 done
  int ph = 0, mst = 0, mcnt = 0, mrq = 0, mto = 0;
  always @(posedge clk) begin
    int dv, per, nto;
    bit tk;
    if (!rst_n) begin
      ph = 0; mst = 0; mcnt = 0; mrq = 0; mto = 0;
    end else begin
      dv  = (psel == 1) ? DA : (psel == 2) ? DB : DC;
      tk  = (psel != 0) && ((ph % dv) == dv - 1);
      per = 1 << (tsel + 2);
      nto = 0;
      if (psel == 0) begin mst = 0; mcnt = 0; end
      else if (mst == 0 || bd) begin mst = rw ? 1 : 2; mcnt = 0; end
      else if (mst == 1) begin
        if (mrq == 1 && !req) begin mst = 2; mcnt = 0; end
      end else if (mst == 2 && tk) begin
        mcnt++;
        if (mcnt >= per) begin mst = 3; nto = 1; end
      end
      mto = nto;
      mrq = req;
      ph  = (ph + 1) % DC;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) check(timeout_o == mto[0], "R3 per-cycle model", timeout_o, mto);
    if (cyc > 150000) begin
      check(0, "watchdog", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // Counts edges after the trigger edge until timeout_o is seen; call right
  // after the negedge that follows the trigger edge.
  task automatic time_it(input int d, input int n, input string tag, output int e);
    bit seen = 0;
    e = 0;
    for (int i = 0; i < n * d + 4; i++) begin
      @(negedge clk);
      e++;
      if (timeout_o) begin seen = 1; break; end
    end
    check(seen && e >= (n - 1) * d + 1 && e <= n * d, tag, e, n * d);
    @(negedge clk);
    check(!timeout_o, "R4 pulse width", timeout_o, 0);
  endtask

  task automatic restart_time(input int d, input int n, input string tag, output int e);
    @(negedge clk); bd = 1'b1;
    @(negedge clk); bd = 1'b0;
    time_it(d, n, tag, e);
  endtask

  task automatic quiet(input int cycles, input string tag);
    int pulses = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (timeout_o) pulses++;
    end
    check(pulses == 0, tag, pulses, 0);
  endtask

  initial begin
    int e, emin, emax;
    repeat (3) @(negedge clk);
    check(timeout_o == 1'b0, "R10 reset low", timeout_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    time_it(DA, 4, "R10 start after reset", e);

    restart_time(DA, 4, "R1 R2 psel1 tsel0", e);
    tsel = 3'd1; psel = 2'd2;
    restart_time(DB, 8, "R1 psel2 tsel1", e);
    tsel = 3'd0; psel = 2'd3;
    restart_time(DC, 4, "R1 psel3 tsel0", e);
    psel = 2'd1; tsel = 3'd3;
    restart_time(DA, 32, "R2 tsel3", e);
    tsel = 3'd7;
    restart_time(DA, 512, "R2 tsel7", e);

    quiet(3 * 512 * DA / 2, "R4 no repeat after timeout");

    tsel = 3'd0;
    emin = 1 << 30; emax = 0;
    for (int off = 0; off < DA; off++) begin
      repeat (off) @(negedge clk);
      restart_time(DA, 4, "R9 window", e);
      if (e < emin) emin = e;
      if (e > emax) emax = e;
    end
    check(emax > emin, "R9 phase spread", emax - emin, 1);

    // R5: restart well before expiry, then time from the restart
    @(negedge clk); bd = 1'b1;
    @(negedge clk); bd = 1'b0;
    repeat (3 * DA) @(negedge clk);
    check(!timeout_o, "R5 no early pulse", timeout_o, 0);
    restart_time(DA, 4, "R5 restart window", e);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); bd = 1'b1;
      @(negedge clk); bd = 1'b0;
      repeat (DA) @(negedge clk);
      if (timeout_o) check(0, "R5 kept alive", 1, 0);
    end
    check(!timeout_o, "R5 kept alive end", timeout_o, 0);

    // R6
    psel = 2'd0;
    quiet(3000, "R6 disabled silent");
    psel = 2'd1;
    @(negedge clk);
    time_it(DA, 4, "R6 enable restarts", e);

    // R7
    rw = 1'b1; req = 1'b1;
    @(negedge clk); bd = 1'b1;
    @(negedge clk); bd = 1'b0;
    quiet(10 * 4 * DA, "R7 held while req high");
    req = 1'b0;
    @(negedge clk);
    time_it(DA, 4, "R7 count from fall", e);
    @(negedge clk); bd = 1'b1;
    @(negedge clk); bd = 1'b0;
    quiet(10 * 4 * DA, "R7 no fall no start");

    // R8
    rw = 1'b0; req = 1'b1;
    restart_time(DA, 4, "R8 immediate start req high", e);
    req = 1'b0;
    restart_time(DA, 4, "R8 immediate start req low", e);

    repeat (5) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule